// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block sits between a host bus and the device side of a simple keyboard controller. The host sees two byte-wide port addresses. The command/status address returns a status word when read and takes a command byte when written. The data address returns the last byte queued for the host when read and takes a command operand when written. The device side offers scancode bytes through a valid/ready handshake. The block accepts a byte only when the keyboard is enabled and nothing is waiting for the host.

Three commands are decoded: enable keyboard, self test, and an LED update. The LED update is a two-step command: the command byte arms it, and the next byte written to the data address sets the indicators. The self test keeps the input-busy flag high for a fixed number of cycles. It then queues a pass byte of 0x55 for the host and sets the system flag. A one-cycle pulse marks each moment a byte becomes available to the host, and can serve as a simple interrupt.

Top module: `kbc_regif`

## Requirements
- R1: A read of address 0x64 returns the status word. From bit 7 down to bit 0 it holds parity error, timeout, auxiliary data, keyboard lock, last-write-was-command, system flag, input busy and output full. Bits 7 to 4 always read 0. `hst_rdata` is combinational in the address and does not depend on `hst_sel`.
- R2: A read of address 0x60 returns the data register. An accepted read of that address clears output full at the same clock edge.
- R3: `scan_ready` is high exactly when the keyboard is enabled and both output full and input busy are low. A byte taken on a handshake edge is in the data register after that edge, and output full is set.
- R4: Command 0xAA holds input busy high for ST_CYCLES cycles, starting at the edge that takes the command. At the last of these edges it loads 0x55 into the data register and sets output full and the system flag.
- R5: Command 0xAE sets `kbd_en`. Only reset clears it.
- R6: Command 0xED arms an LED update. The next data-address write loads bits 2:0 of its byte into `led`. A data-address write with no update armed leaves `led` unchanged.
- R7: Command bytes other than 0xAA, 0xAE and 0xED change nothing. Any command written while input busy is high changes nothing except bit 3 of the status word.
- R8: Status bit 3 becomes 1 after a write to 0x64 and 0 after a write to 0x60.
- R9: After reset the status word reads 0x00, the data register reads 0x00, `led` is 0 and `kbd_en` is 0.
- R10: `obf_pulse` is high for one cycle, the first cycle in which output full reads 1 after having been 0.
- R11: If a data-address read and self-test completion fall on the same edge, output full stays set and the data register holds 0x55 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 8 | Port address (0x60 data, 0x64 command/status) |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Status word or data register, selected by address |
| scan_valid | input | 1 | Device offers a scancode |
| scan_byte | input | 8 | Offered scancode |
| scan_ready | output | 1 | Block can take a scancode this cycle |
| kbd_en | output | 1 | Keyboard enabled flag |
| led | output | LED_W | Indicator state |
| obf_pulse | output | 1 | Byte-available pulse |

## Verification
Two pairs of events can meet on one edge. In the first, the host reads the data address in the cycle the self test completes. This is provoked by timing the read to land on the last busy edge, and judged by output full staying set and a later read returning 0x55. In the second, the host reads while the device holds a scancode offer against a full buffer. The offer must not be taken on the read edge and must be taken on the following edge. A behavioural model compared on every clock judges both cases.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SELFTEST = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_ENABLE   = 8'hAE;
    localparam logic [BYTE_W-1:0] CMD_SETLED   = 8'hED;
    localparam logic [BYTE_W-1:0] SELFTEST_OK  = 8'h55;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SELFTEST,
        OP_ENABLE,
        OP_SETLED
    } cmd_op_e;

    // Bit order is visible to host software; keep it fixed.
    typedef struct packed {
        logic parity_err;
        logic timeout;
        logic aux_data;
        logic kbd_lock;
        logic last_cmd;
        logic sys_flag;
        logic in_busy;
        logic out_full;
    } status_t;

    typedef struct packed {
        logic              rd_data;
        logic              wr_data;
        logic              wr_cmd;
        logic [BYTE_W-1:0] wdata;
    } host_req_t;

    function automatic cmd_op_e decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_op_e op;
        case (b)
            CMD_SELFTEST: op = OP_SELFTEST;
            CMD_ENABLE:   op = OP_ENABLE;
            CMD_SETLED:   op = OP_SETLED;
            default:      op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
    import kbc_pkg::*;
#(
    parameter logic [7:0] DATA_ADDR = 8'h60,
    parameter logic [7:0] CMD_ADDR  = 8'h64
) (
    input  logic              hst_sel,
    input  logic              hst_we,
    input  logic [7:0]        hst_addr,
    input  logic [BYTE_W-1:0] hst_wdata,
    output host_req_t         req
);

    logic hit_data;
    logic hit_cmd;

    assign hit_data = (hst_addr == DATA_ADDR);
    assign hit_cmd  = (hst_addr == CMD_ADDR);

    always_comb begin
        req.rd_data = hst_sel & ~hst_we & hit_data;
        req.wr_data = hst_sel &  hst_we & hit_data;
        req.wr_cmd  = hst_sel &  hst_we & hit_cmd;
        req.wdata   = hst_wdata;
    end

endmodule

// File: rtl/kbc_cmd_seq.sv
module kbc_cmd_seq
    import kbc_pkg::*;
#(
    parameter int ST_CYCLES = 8,
    parameter int LED_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  host_req_t        req,
    output logic             kbd_en,
    output logic [LED_W-1:0] led,
    output logic             in_busy,
    output logic             sys_flag,
    output logic             last_cmd,
    output logic             st_done
);

    localparam int CNT_W = (ST_CYCLES > 1) ? $clog2(ST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             led_armed;
    cmd_op_e          op;

    assign op      = decode_cmd(req.wdata);
    assign st_done = in_busy & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            kbd_en    <= 1'b0;
            led       <= '0;
            in_busy   <= 1'b0;
            sys_flag  <= 1'b0;
            last_cmd  <= 1'b0;
            led_armed <= 1'b0;
            cnt       <= '0;
        end else begin
            if (in_busy) begin
                if (cnt == '0) begin
                    in_busy  <= 1'b0;
                    sys_flag <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (req.wr_cmd) begin
                last_cmd <= 1'b1;
                if (!in_busy) begin
                    case (op)
                        OP_SELFTEST: begin
                            in_busy <= 1'b1;
                            cnt     <= CNT_LOAD;
                        end
                        OP_ENABLE: kbd_en    <= 1'b1;
                        OP_SETLED: led_armed <= 1'b1;
                        default: ;
                    endcase
                end
            end
            if (req.wr_data) begin
                last_cmd <= 1'b0;
                if (led_armed) begin
                    led       <= req.wdata[LED_W-1:0];
                    led_armed <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_data,
    input  logic              st_done,
    input  logic              kbd_en,
    input  logic              in_busy,
    input  logic              scan_valid,
    input  logic [BYTE_W-1:0] scan_byte,
    output logic              scan_ready,
    output logic              out_full,
    output logic [BYTE_W-1:0] data_q,
    output logic              obf_pulse
);

    logic              full_n;
    logic [BYTE_W-1:0] data_n;

    assign scan_ready = kbd_en & ~out_full & ~in_busy;

    // Later assignments take priority: a load wins over a read clear.
    always_comb begin
        full_n = out_full;
        data_n = data_q;
        if (rd_data) full_n = 1'b0;
        if (scan_valid && scan_ready) begin
            data_n = scan_byte;
            full_n = 1'b1;
        end
        if (st_done) begin
            data_n = SELFTEST_OK;
            full_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_full  <= 1'b0;
            data_q    <= '0;
            obf_pulse <= 1'b0;
        end else begin
            out_full  <= full_n;
            data_q    <= data_n;
            obf_pulse <= full_n & ~out_full;
        end
    end

endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
    import kbc_pkg::*;
#(
    parameter logic [7:0] DATA_ADDR = 8'h60,
    parameter logic [7:0] CMD_ADDR  = 8'h64,
    parameter int         ST_CYCLES = 8,
    parameter int         LED_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hst_sel,
    input  logic             hst_we,
    input  logic [7:0]       hst_addr,
    input  logic [7:0]       hst_wdata,
    output logic [7:0]       hst_rdata,
    input  logic             scan_valid,
    input  logic [7:0]       scan_byte,
    output logic             scan_ready,
    output logic             kbd_en,
    output logic [LED_W-1:0] led,
    output logic             obf_pulse
);

    host_req_t         req;
    status_t           st;
    logic [7:0]        status_w;
    logic [BYTE_W-1:0] data_q;
    logic              in_busy;
    logic              sys_flag;
    logic              last_cmd;
    logic              st_done;
    logic              out_full;

    kbc_host_decode #(
        .DATA_ADDR(DATA_ADDR),
        .CMD_ADDR (CMD_ADDR)
    ) u_dec (
        .hst_sel  (hst_sel),
        .hst_we   (hst_we),
        .hst_addr (hst_addr),
        .hst_wdata(hst_wdata),
        .req      (req)
    );

    kbc_cmd_seq #(
        .ST_CYCLES(ST_CYCLES),
        .LED_W    (LED_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .kbd_en  (kbd_en),
        .led     (led),
        .in_busy (in_busy),
        .sys_flag(sys_flag),
        .last_cmd(last_cmd),
        .st_done (st_done)
    );

    kbc_outbuf u_obuf (
        .clk       (clk),
        .rst       (rst),
        .rd_data   (req.rd_data),
        .st_done   (st_done),
        .kbd_en    (kbd_en),
        .in_busy   (in_busy),
        .scan_valid(scan_valid),
        .scan_byte (scan_byte),
        .scan_ready(scan_ready),
        .out_full  (out_full),
        .data_q    (data_q),
        .obf_pulse (obf_pulse)
    );

    always_comb begin
        st            = '0;
        st.last_cmd   = last_cmd;
        st.sys_flag   = sys_flag;
        st.in_busy    = in_busy;
        st.out_full   = out_full;
    end

    assign status_w  = st;
    assign hst_rdata = (hst_addr == CMD_ADDR) ? status_w : data_q;

endmodule

// File: rtl/kbc_regif_chk.sv
module kbc_regif_chk #(
    parameter logic [7:0] DATA_ADDR = 8'h60,
    parameter logic [7:0] CMD_ADDR  = 8'h64,
    parameter int         LED_W     = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             hst_sel,
    input logic             hst_we,
    input logic [7:0]       hst_addr,
    input logic             scan_valid,
    input logic [7:0]       scan_byte,
    input logic             scan_ready,
    input logic             kbd_en,
    input logic [LED_W-1:0] led,
    input logic             obf_pulse,
    input logic [7:0]       st_word,
    input logic [7:0]       data_q
);

    logic wr_cmd, wr_dat, rd_dat;
    assign wr_cmd = hst_sel && hst_we && (hst_addr == CMD_ADDR);
    assign wr_dat = hst_sel && hst_we && (hst_addr == DATA_ADDR);
    assign rd_dat = hst_sel && !hst_we && (hst_addr == DATA_ADDR);

    p_ready_gate_r3: assert property (@(posedge clk) disable iff (rst)
        scan_ready |-> (kbd_en && !st_word[0] && !st_word[1]));

    p_accept_load_r3: assert property (@(posedge clk) disable iff (rst)
        (scan_valid && scan_ready) |=> (st_word[0] && data_q == $past(scan_byte)));

    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && st_word[0] && !st_word[1]) |=> !st_word[0]);

    p_pulse_full_r10: assert property (@(posedge clk) disable iff (rst)
        obf_pulse |-> st_word[0]);

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        obf_pulse |=> !obf_pulse);

    p_enable_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        kbd_en |=> kbd_en);

    p_cmd_marks_r8: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> st_word[3]);

    p_led_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_dat |=> $stable(led));

    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && st_word[1]) |=> $stable(kbd_en));

endmodule

bind kbc_regif kbc_regif_chk #(
    .DATA_ADDR(DATA_ADDR),
    .CMD_ADDR (CMD_ADDR),
    .LED_W    (LED_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_sel   (hst_sel),
    .hst_we    (hst_we),
    .hst_addr  (hst_addr),
    .scan_valid(scan_valid),
    .scan_byte (scan_byte),
    .scan_ready(scan_ready),
    .kbd_en    (kbd_en),
    .led       (led),
    .obf_pulse (obf_pulse),
    .st_word   (status_w),
    .data_q    (data_q)
);

// File: tb/test_kbc_regif.sv
module test_kbc_regif;

    localparam int CLK_PERIOD = 10;
    localparam int ST         = 8;
    localparam logic [7:0] A_DATA = 8'h60;
    localparam logic [7:0] A_CMD  = 8'h64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hst_sel = 1'b0, hst_we = 1'b0;
    logic [7:0] hst_addr = A_CMD, hst_wdata = 8'h00;
    logic [7:0] hst_rdata;
    logic       scan_valid = 1'b0;
    logic [7:0] scan_byte = 8'h00;
    logic       scan_ready, kbd_en, obf_pulse;
    logic [2:0] led;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_regif #(.ST_CYCLES(ST)) i_kbc_regif (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .scan_valid(scan_valid), .scan_byte(scan_byte), .scan_ready(scan_ready),
        .kbd_en(kbd_en), .led(led), .obf_pulse(obf_pulse)
    );

    // Behavioural reference model
    bit m_obf, m_busy, m_sysf, m_a2, m_en, m_pend, m_pulse;
    int m_left;
    logic [7:0] m_data;
    logic [2:0] m_led;

    always @(posedge clk) begin
        if (rst) begin
            m_obf = 0; m_busy = 0; m_sysf = 0; m_a2 = 0; m_en = 0;
            m_pend = 0; m_pulse = 0; m_left = 0; m_data = 0; m_led = 0;
        end else begin
            bit old_obf, old_busy, done, acc;
            old_obf = m_obf; old_busy = m_busy; done = 0;
            acc = scan_valid && m_en && !m_obf && !m_busy;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; done = 1; m_sysf = 1; end
            end
            if (hst_sel && !hst_we && hst_addr == A_DATA) m_obf = 0;
            if (acc) begin m_data = scan_byte; m_obf = 1; end
            if (done) begin m_data = 8'h55; m_obf = 1; end
            if (hst_sel && hst_we && hst_addr == A_CMD) begin
                m_a2 = 1;
                if (!old_busy) begin
                    if (hst_wdata == 8'hAA) begin m_busy = 1; m_left = ST; end
                    else if (hst_wdata == 8'hAE) m_en = 1;
                    else if (hst_wdata == 8'hED) m_pend = 1;
                end
            end
            if (hst_sel && hst_we && hst_addr == A_DATA) begin
                m_a2 = 0;
                if (m_pend) begin m_led = hst_wdata[2:0]; m_pend = 0; end
            end
            m_pulse = m_obf && !old_obf;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 rdata vs model", hst_rdata,
                (hst_addr == A_CMD) ? {4'b0, m_a2, m_sysf, m_busy, m_obf} : m_data);
            chk("R6 led vs model", {5'b0, led}, {5'b0, m_led});
            chk("R5 kbd_en vs model", {7'b0, kbd_en}, {7'b0, m_en});
            chk("R3 scan_ready vs model", {7'b0, scan_ready},
                {7'b0, m_en && !m_obf && !m_busy});
            chk("R10 obf_pulse vs model", {7'b0, obf_pulse}, {7'b0, m_pulse});
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        hst_sel = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
        @(posedge clk); #1;
        hst_sel = 0; hst_we = 0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        hst_sel = 1; hst_we = 0; hst_addr = a;
        #1 d = hst_rdata;
        @(posedge clk); #1;
        hst_sel = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9 reset state
        peek(A_CMD, v);  chk("R9 status after reset", v, 8'h00);
        peek(A_DATA, v); chk("R9 data after reset", v, 8'h00);
        chk("R9 led after reset", {5'b0, led}, 8'h00);
        chk("R9 kbd_en after reset", {7'b0, kbd_en}, 8'h00);

        // R3 disabled keyboard takes nothing
        @(posedge clk); #1 scan_valid = 1; scan_byte = 8'h11;
        repeat (3) @(posedge clk); #1 scan_valid = 0;
        peek(A_CMD, v); chk("R3 no accept while disabled", v, 8'h00);

        // R5 / R8 enable
        host_write(A_CMD, 8'hAE);
        chk("R5 enable command", {7'b0, kbd_en}, 8'h01);
        peek(A_CMD, v); chk("R8 last write was command", v, 8'h08);

        // R3 / R10 accept one scancode
        @(posedge clk); #1 scan_valid = 1; scan_byte = 8'h1C;
        @(posedge clk); #1 scan_valid = 0;
        chk("R10 pulse after accept", {7'b0, obf_pulse}, 8'h01);
        peek(A_CMD, v); chk("R3 output full after accept", v, 8'h09);

        // R2 / R3 offer held against a full buffer; read frees it
        @(posedge clk); #1 scan_valid = 1; scan_byte = 8'h2A;
        repeat (2) @(posedge clk); #1;
        chk("R3 ready low while full", {7'b0, scan_ready}, 8'h00);
        host_read(A_DATA, v); chk("R2 read first scancode", v, 8'h1C);
        @(posedge clk); #1 scan_valid = 0;
        host_read(A_DATA, v); chk("R3 held offer taken after read", v, 8'h2A);
        peek(A_CMD, v); chk("R2 read clears output full", v & 8'h01, 8'h00);

        // R6 LED update
        host_write(A_CMD, 8'hED);
        host_write(A_DATA, 8'hFD);
        chk("R6 led low bits", {5'b0, led}, 8'h05);
        host_write(A_DATA, 8'h02);
        chk("R6 unarmed data write ignored", {5'b0, led}, 8'h05);
        peek(A_CMD, v); chk("R8 last write was data", v & 8'h08, 8'h00);

        // R7 unsupported command
        host_write(A_CMD, 8'h12);
        peek(A_CMD, v); chk("R7 unknown command status", v, 8'h08);
        chk("R7 unknown command led", {5'b0, led}, 8'h05);

        // R4 / R7 / R11 self test
        host_write(A_CMD, 8'hAA);                 // taken at E0
        peek(A_CMD, v); chk("R4 input busy during test", v & 8'h02, 8'h02);
        chk("R4 ready low while busy", {7'b0, scan_ready}, 8'h00);
        host_write(A_CMD, 8'hED);                 // E2, ignored
        host_write(A_DATA, 8'h07);                // E4
        chk("R7 command during busy ignored", {5'b0, led}, 8'h05);
        repeat (ST - 6) @(posedge clk);
        host_read(A_DATA, v);                     // sampled at E_ST
        peek(A_CMD, v); chk("R11 full kept on coincident read", v, 8'h05);
        host_read(A_DATA, v); chk("R4 self test pass byte", v, 8'h55);
        peek(A_CMD, v); chk("R4 system flag kept", v, 8'h04);

        // R3 keyboard still works after test
        @(posedge clk); #1 scan_valid = 1; scan_byte = 8'h3B;
        @(posedge clk); #1 scan_valid = 0;
        host_read(A_DATA, v); chk("R3 scancode after test", v, 8'h3B);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule